// File: doc/BRIEF.md
# Transmit Buffer with Collision Rewind and Delayed Release

This block is the byte-wide transmit buffer that sits between a DMA writer and a transmit MAC. The writer pushes frame bytes, each tagged with an end-of-frame bit. The MAC pulls them one at a time. While a frame is going out, the block keeps its first byte reachable, so a collision early in the frame can be answered by replaying the frame straight from the buffer.

Space that a frame occupies is only handed back to the writer once more bytes of that frame have gone out than a programmable release threshold allows. From then on space is freed byte by byte as the MAC reads. If a collision arrives after that point, the start of the frame has already been given away. The block then pulses a release-error flag and silently discards the rest of the frame up to its end-of-frame byte, so the host must supply the frame again. The read side then moves on to the next frame.

Top module: `tx_rewind_fifo`

## Requirements
- R1: After reset the writer sees a free count equal to DEPTH (2048 by default), read data is not valid, and the release-error flag is low.
- R2: The free count equals DEPTH minus the bytes written and not yet released. A write presented while the free count is zero is ignored and leaves stored data and the free count unchanged.
- R3: While the number of bytes read from the current frame is at most the release threshold, reading does not change the free count.
- R4: Once the count of bytes read from the current frame exceeds the threshold, every byte read so far in that frame is released, and each further read of the frame releases one byte.
- R5: A collision while the read count has not exceeded the threshold moves reading back to the first byte of the frame. The frame is then read again with identical data, and the free count is unchanged by the rewind.
- R6: A collision after the threshold has been exceeded raises the release-error flag for exactly one cycle, starting the cycle after the collision. The remaining bytes of the frame, up to and including its end-of-frame byte, are discarded and released, and the next frame is then presented from its first byte.
- R7: Each stored byte carries a ninth bit, the end-of-frame marker, which appears on the rd_last output with that byte. Reading the end-of-frame byte releases the whole frame and resets the read count for the next frame.
- R8: rd_valid is low while the buffer holds no unread byte or while a frame is being discarded. A read request made while rd_valid is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one byte |
| wr_data | input | 8 | Byte to store |
| wr_last | input | 1 | Byte is the end of its frame |
| wr_free | output | AW+1 | Bytes the writer may still store |
| rel_thresh | input | AW | Release threshold in bytes |
| rd_en | input | 1 | MAC consumes the presented byte |
| col | input | 1 | Collision on the current frame |
| rd_valid | output | 1 | rd_data and rd_last are valid |
| rd_data | output | 8 | Byte presented to the MAC |
| rd_last | output | 1 | Presented byte ends its frame |
| rel_err | output | 1 | One-cycle pulse: collision came too late to replay |

## Verification
The main sweep uses a six-byte frame and crosses every release threshold from zero to six with every collision point from zero to five bytes read. This separates the rewind outcome from the release-error outcome exactly at the boundary where the read count first exceeds the threshold. After each byte, the free count is compared with arithmetic from the threshold, which shows whether release starts one byte early or late. Further patterns put a second frame behind a dropped one to show the discard stops at the end-of-frame bit, fill the buffer to zero free space and push extra bytes that must vanish, and issue reads on an empty buffer that must not move the read position.

// File: rtl/txr_pkg.sv
// Package: shared constants and the stored word type of the rewind transmit buffer.
// Assumes byte-wide data; the end-of-frame marker travels as a ninth bit.
package txr_pkg;
    localparam int TXR_BYTE_W = 8;

    typedef struct packed {
        logic                  last;
        logic [TXR_BYTE_W-1:0] data;
    } txr_word_t;
endpackage

// File: rtl/txr_store.sv
// Module: txr_store
// Holds DEPTH nine-bit words. One synchronous write port, one combinational read port.
// Assumes the controller never reads an address in the cycle it writes it while
// the read data is used (reads are gated valid only when the word is present).
module txr_store
    import txr_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  txr_word_t       wword,
    input  logic [AW-1:0]   raddr,
    output txr_word_t       rword
);
    txr_word_t mem_q [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wword;
        end
    end

    // Present the word at the read position.
    assign rword = mem_q[raddr];
endmodule

// File: rtl/txr_wrside.sv
// Module: txr_wrside
// Owns the write pointer and computes the free count from the release pointer,
// so bytes the reader may still replay are never overwritten.
// Assumes pointers carry one extra wrap bit.
module txr_wrside #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW:0]   relp,
    output logic [AW:0]   wp,
    output logic [AW:0]   free,
    output logic          we
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    logic [AW:0] wp_q;
    logic [AW:0] held;

    // Bytes held between release and write pointers.
    assign held = wp_q - relp;
    assign free = DEPTH_V - held;
    assign we   = wr_en && (free != '0);
    assign wp   = wp_q;

    // Advance the write pointer on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
        end else if (we) begin
            wp_q <= wp_q + 1'b1;
        end
    end
endmodule

// File: rtl/txr_rdside.sv
// Module: txr_rdside
// Read, rewind, release and discard control. Keeps the release pointer at the
// frame start until the per-frame read count exceeds the threshold, then drags it
// along with the read pointer. A late collision raises an error and discards to
// end of frame. Assumes head_last is the marker of the word at the read pointer.
module txr_rdside #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW:0]   wp,
    input  logic          rd_en,
    input  logic          col,
    input  logic [AW-1:0] thresh,
    input  logic          head_last,
    output logic [AW:0]   rp,
    output logic [AW:0]   relp,
    output logic          rd_valid,
    output logic          rel_err,
    output logic          past,
    output logic          drop
);
    logic [AW:0] rp_q, relp_q, sent_q, sent_nx, rp_nx;
    logic        past_q, drop_q, err_q;
    logic        avail, take;

    assign avail    = (wp != rp_q);
    assign rd_valid = avail && !drop_q;
    assign take     = rd_en && rd_valid && !col;
    assign sent_nx  = sent_q + 1'b1;
    assign rp_nx    = rp_q + 1'b1;

    assign rp      = rp_q;
    assign relp    = relp_q;
    assign rel_err = err_q;
    assign past    = past_q;
    assign drop    = drop_q;

    // Sequence collisions, discards and normal reads; collision wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q   <= '0;
            relp_q <= '0;
            sent_q <= '0;
            past_q <= 1'b0;
            drop_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (col && !drop_q) begin
                if (past_q) begin
                    drop_q <= 1'b1;
                    err_q  <= 1'b1;
                end else begin
                    rp_q   <= relp_q;
                    sent_q <= '0;
                end
            end else if (drop_q) begin
                if (avail) begin
                    rp_q   <= rp_nx;
                    relp_q <= rp_nx;
                    if (head_last) begin
                        drop_q <= 1'b0;
                        sent_q <= '0;
                        past_q <= 1'b0;
                    end
                end
            end else if (take) begin
                rp_q <= rp_nx;
                if (head_last) begin
                    relp_q <= rp_nx;
                    sent_q <= '0;
                    past_q <= 1'b0;
                end else begin
                    sent_q <= sent_nx;
                    if (past_q || (sent_nx > {1'b0, thresh})) begin
                        past_q <= 1'b1;
                        relp_q <= rp_nx;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tx_rewind_fifo.sv
// Module: tx_rewind_fifo (top)
// Transmit buffer between a DMA writer and a MAC reader with collision replay
// from the buffer and threshold-delayed release of frame storage.
// Assumes DEPTH is a power of two and rel_thresh is held stable during a frame.
module tx_rewind_fifo
    import txr_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TXR_BYTE_W-1:0] wr_data,
    input  logic                  wr_last,
    output logic [AW:0]           wr_free,
    input  logic [AW-1:0]         rel_thresh,
    input  logic                  rd_en,
    input  logic                  col,
    output logic                  rd_valid,
    output logic [TXR_BYTE_W-1:0] rd_data,
    output logic                  rd_last,
    output logic                  rel_err
);
    logic [AW:0] wp, rp, relp;
    logic        we, past, drop;
    txr_word_t   wword, rword;

    assign wword.data = wr_data;
    assign wword.last = wr_last;
    assign rd_data    = rword.data;
    assign rd_last    = rword.last;

    txr_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (wp[AW-1:0]),
        .wword (wword),
        .raddr (rp[AW-1:0]),
        .rword (rword)
    );

    txr_wrside #(.DEPTH(DEPTH)) u_wr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .relp  (relp),
        .wp    (wp),
        .free  (wr_free),
        .we    (we)
    );

    txr_rdside #(.DEPTH(DEPTH)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wp        (wp),
        .rd_en     (rd_en),
        .col       (col),
        .thresh    (rel_thresh),
        .head_last (rword.last),
        .rp        (rp),
        .relp      (relp),
        .rd_valid  (rd_valid),
        .rel_err   (rel_err),
        .past      (past),
        .drop      (drop)
    );
endmodule

// File: rtl/txr_checker.sv
// Module: txr_checker
// Temporal checks on the rewind transmit buffer, attached to the top by bind.
module txr_checker #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst_n,
    input logic [AW:0] wr_free,
    input logic        col,
    input logic        rd_valid,
    input logic        rel_err,
    input logic [AW:0] wp,
    input logic [AW:0] rp,
    input logic [AW:0] relp,
    input logic        past,
    input logic        drop
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    // R2: free count never exceeds capacity
    a_r2_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wr_free <= DEPTH_V);

    // R2: nothing is stored while full
    a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_free == '0) |=> (wp == $past(wp)));

    // R4: release pointer never passes the read pointer
    a_r4_release_order: assert property (@(posedge clk) disable iff (!rst_n)
        (rp - relp) <= (wp - relp));

    // R5: early collision returns reading to the frame start
    a_r5_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (col && !past && !drop) |=> (rp == $past(relp)));

    // R6: error only follows a collision and lasts one cycle
    a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |-> $past(col));
    a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |=> !rel_err);

    // R8: no valid data while empty
    a_r8_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (wp == rp) |-> !rd_valid);
endmodule

bind tx_rewind_fifo txr_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_free  (wr_free),
    .col      (col),
    .rd_valid (rd_valid),
    .rel_err  (rel_err),
    .wp       (wp),
    .rp       (rp),
    .relp     (relp),
    .past     (past),
    .drop     (drop)
);

// File: tb/test_tx_rewind_fifo.sv
`timescale 1ns/1ps
module test_tx_rewind_fifo;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          wr_last = 1'b0;
    logic [AW:0]   wr_free;
    logic [AW-1:0] rel_thresh = '0;
    logic          rd_en = 1'b0;
    logic          col = 1'b0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic          rd_last;
    logic          rel_err;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    tx_rewind_fifo #(.DEPTH(DEPTH)) i_tx_rewind_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_last(wr_last), .wr_free(wr_free), .rel_thresh(rel_thresh),
        .rd_en(rd_en), .col(col), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_last(rd_last), .rel_err(rel_err)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int f, input int i);
        return 8'((f * 16 + i) & 255);
    endfunction

    task automatic write_frame(input int f, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_data = pat(f, i);
            wr_last = (i == len - 1);
        end
        @(negedge clk);
        wr_en   = 1'b0;
        wr_last = 1'b0;
    endtask

    task automatic read_byte(input string req, input logic [7:0] ed, input bit el);
        @(negedge clk);
        check({req, " valid"}, int'(rd_valid), 1);
        check({req, " data"}, int'(rd_data), int'(ed));
        check({req, " last"}, int'(rd_last), int'(el));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic collide();
        @(negedge clk);
        col = 1'b1;
        @(negedge clk);
        col = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int fid;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 free", int'(wr_free), DEPTH);
        check("R1 valid", int'(rd_valid), 0);
        check("R1 err", int'(rel_err), 0);

        // R8 reads on an empty buffer do not move the read position
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        check("R8 empty valid", int'(rd_valid), 0);
        write_frame(1, 2);
        read_byte("R8 after empty read", pat(1, 0), 1'b0);
        read_byte("R8 after empty read", pat(1, 1), 1'b1);
        check("R7 frame freed", int'(wr_free), DEPTH);

        // Sweep threshold x collision point on a six-byte frame (R3..R7)
        fid = 2;
        for (int thr = 0; thr <= 6; thr++) begin
            for (int k = 0; k < 6; k++) begin
                rel_thresh = AW'(thr);
                write_frame(fid, 6);
                check("R2 free after write", int'(wr_free), DEPTH - 6);
                for (int j = 0; j < k; j++) begin
                    read_byte("R5 first pass", pat(fid, j), 1'b0);
                    check(((j + 1) > thr) ? "R4 free release" : "R3 free held",
                          int'(wr_free), DEPTH - 6 + (((j + 1) > thr) ? (j + 1) : 0));
                end
                collide();
                check("R6 err on late collision", int'(rel_err), (k > thr) ? 1 : 0);
                if (k > thr) begin
                    repeat (8) @(negedge clk);
                    check("R6 err one cycle", int'(rel_err), 0);
                    check("R6 discarded valid", int'(rd_valid), 0);
                    check("R6 discarded free", int'(wr_free), DEPTH);
                end else begin
                    check("R5 free after rewind", int'(wr_free), DEPTH - 6);
                    for (int j = 0; j < 6; j++) begin
                        read_byte("R5 replay", pat(fid, j), j == 5);
                    end
                    check("R7 free after eof", int'(wr_free), DEPTH);
                end
                fid++;
            end
        end

        // R6 discard stops at end of frame; next frame intact
        rel_thresh = AW'(1);
        write_frame(100, 5);
        write_frame(101, 3);
        check("R2 two frames free", int'(wr_free), DEPTH - 8);
        for (int j = 0; j < 3; j++) read_byte("R6 frame A", pat(100, j), 1'b0);
        collide();
        check("R6 err", int'(rel_err), 1);
        repeat (6) @(negedge clk);
        check("R6 free after drop", int'(wr_free), DEPTH - 3);
        for (int j = 0; j < 3; j++) read_byte("R6 next frame", pat(101, j), j == 2);
        check("R6 free end", int'(wr_free), DEPTH);

        // R2 writes ignored when full
        rel_thresh = AW'(0);
        write_frame(7, 16);
        check("R2 full free", int'(wr_free), 0);
        write_frame(12, 3);
        check("R2 still full", int'(wr_free), 0);
        for (int j = 0; j < 16; j++) read_byte("R2 no overwrite", pat(7, j), j == 15);
        check("R2 free restored", int'(wr_free), DEPTH);
        check("R8 empty at end", int'(rd_valid), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule